// File: doc/BRIEF.md
# Event-Based Power Estimator

The estimator forms a digital figure for the power drawn by a chip with several compute cores, one graphics engine and one I/O domain. It uses activity counts in place of analog sensing. Every cycle each domain reports how many energy-relevant events it produced. The block adds these counts up over a fixed sample interval. At the end of the interval it converts each domain's count into an active-power figure by multiplying it by a programmable energy weight. It also forms a leakage figure from a per-die base value, which is scaled by two programmable fixed-point multiplier tables: one indexed by the present supply-voltage code and one by the present junction-temperature code. The package figure is the sum of all domain figures plus the scaled leakage.

Software loads the weights, the leakage base and both tables through a small write port. It reads the per-domain, leakage and package figures through a combinational read port. A one-cycle strobe marks each refresh of the estimates. Arithmetic clamps at full scale and never wraps.

Top module: `pwr_est_top`

## Requirements
- R1: Each domain's event count covers exactly the INTERVAL cycles of one interval, including the final cycle. Counts restart from zero for the next interval, so no event carries over.
- R2: An interval count clamps at 2^CNT_W-1 (255 by default) and does not wrap.
- R3: The estimate for domain d (cores 0..NCORE-1, graphics NCORE, I/O NCORE+1) is min(count*weight, 2^PWR_W-1).
- R4: Leakage is (base * vtab[vcode] * ttab[tcode]) >> (2*FRAC), clamped to 2^PWR_W-1. Table entries are unsigned fixed point with FRAC fraction bits, so 64 means 1.0 by default.
- R5: The package estimate is min(sum of all domain estimates + leakage, 2^PWR_W-1).
- R6: est_valid is high for exactly one cycle every INTERVAL cycles. The estimates change only on the edge that raises it.
- R7: After reset, est_valid is low and every readable estimate is zero.
- R8: The write map is as follows. Addresses 0..ND-1 hold the weights, 0x10 holds the leakage base, 0x20+v holds vtab[v] and 0x30+t holds ttab[t]. The read map is as follows. Addresses 0..ND-1 return the domain estimates, ND returns leakage and ND+1 returns the package estimate.
- R9: The voltage and temperature codes used are the ones present in the last cycle of the interval. Earlier values within the interval have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_ev | input | NCORE*EV_W | Per-core event counts this cycle, core 0 in the low bits |
| gfx_ev | input | EV_W | Graphics event count this cycle |
| io_ev | input | EV_W | I/O event count this cycle |
| vcode | input | VC_W | Present supply-voltage code |
| tcode | input | TC_W | Present temperature code |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 6 | Configuration write address |
| wr_data | input | BASE_W | Configuration write data |
| rd_addr | input | 6 | Estimate read address |
| rd_data | output | PWR_W | Estimate read data |
| est_valid | output | 1 | One-cycle refresh strobe |

## Verification
On every cycle the assertions check several properties. The strobe must be one cycle wide and sit at the interval start. Estimates must hold still between strobes. Counters must restart at zero after each sample and stay pinned once clamped. The package figure must never fall below leakage or below any single domain. The arithmetic itself, the register map and the point at which the operating codes are sampled can only be shown by the bench. It sweeps every voltage and temperature code pair under varied event rates and weights. It includes clamping intervals and zero-activity intervals, and it compares each read against figures computed from the formulas.

// File: rtl/pe_pkg.sv
package pe_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] A_BASE = 6'h10;
    localparam logic [1:0] PG_VTAB = 2'd2;
    localparam logic [1:0] PG_TTAB = 2'd3;
endpackage

// File: rtl/pe_evt_counter.sv
module pe_evt_counter #(
    parameter int EV_W  = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  ev,
    input  logic             clr,
    output logic [CNT_W-1:0] total
);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W:0]   ev_x, sum;

    always_comb begin
        ev_x = '0;
        ev_x[EV_W-1:0] = ev;
        sum = {1'b0, cnt_q} + ev_x;
        total = (sum > MAXV) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
        cnt_d = clr ? '0 : total;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);
    a_r2_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {CNT_W{1'b1}} && !clr) |=> cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pe_leak_scale.sv
module pe_leak_scale #(
    parameter int BASE_W = 12,
    parameter int LUT_W  = 8,
    parameter int FRAC   = 6,
    parameter int PWR_W  = 16
) (
    input  logic [BASE_W-1:0] base,
    input  logic [LUT_W-1:0]  vmul,
    input  logic [LUT_W-1:0]  tmul,
    output logic [PWR_W-1:0]  leak
);
    localparam int WL = BASE_W + 2*LUT_W + PWR_W;
    localparam logic [WL-1:0] PMAX = WL'({PWR_W{1'b1}});

    logic [WL-1:0] prod, scaled;

    always_comb begin
        prod   = WL'(base) * WL'(vmul) * WL'(tmul);
        scaled = prod >> (2*FRAC);
        leak   = (scaled > PMAX) ? {PWR_W{1'b1}} : scaled[PWR_W-1:0];
    end
endmodule

// File: rtl/pwr_est_top.sv
module pwr_est_top
    import pe_pkg::*;
#(
    parameter int NCORE    = 2,
    parameter int EV_W     = 5,
    parameter int CNT_W    = 8,
    parameter int WGT_W    = 8,
    parameter int PWR_W    = 16,
    parameter int BASE_W   = 12,
    parameter int LUT_W    = 8,
    parameter int FRAC     = 6,
    parameter int VC_W     = 2,
    parameter int TC_W     = 2,
    parameter int INTERVAL = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCORE*EV_W-1:0]   core_ev,
    input  logic [EV_W-1:0]         gfx_ev,
    input  logic [EV_W-1:0]         io_ev,
    input  logic [VC_W-1:0]         vcode,
    input  logic [TC_W-1:0]         tcode,
    input  logic                    wr_en,
    input  logic [5:0]              wr_addr,
    input  logic [BASE_W-1:0]       wr_data,
    input  logic [5:0]              rd_addr,
    output logic [PWR_W-1:0]        rd_data,
    output logic                    est_valid
);
    localparam int ND     = NCORE + 2;
    localparam int VN     = 1 << VC_W;
    localparam int TN     = 1 << TC_W;
    localparam int TICK_W = $clog2(INTERVAL);
    localparam int WM     = PWR_W + CNT_W + WGT_W;
    localparam int WS     = PWR_W + $clog2(ND + 1) + 1;
    localparam logic [TICK_W-1:0] LAST = TICK_W'(INTERVAL - 1);

    typedef struct packed {
        logic [TICK_W-1:0]             tick;
        logic                          valid;
        logic [ND-1:0][PWR_W-1:0]      dom;
        logic [PWR_W-1:0]              leak;
        logic [PWR_W-1:0]              pkg;
        logic [ND-1:0][WGT_W-1:0]      wgt;
        logic [BASE_W-1:0]             base;
        logic [VN-1:0][LUT_W-1:0]      vtab;
        logic [TN-1:0][LUT_W-1:0]      ttab;
    } st_t;

    st_t s_d, s_q;

    logic                          boundary;
    logic [ND-1:0][EV_W-1:0]       ev_all;
    logic [ND-1:0][CNT_W-1:0]      cnt_tot;
    logic [ND-1:0][PWR_W-1:0]      dom_nx;
    logic [PWR_W-1:0]              leak_nx, pkg_nx;
    logic [WM-1:0]                 prod;
    logic [WS-1:0]                 acc;

    assign boundary = (s_q.tick == LAST);

    genvar g;
    generate
        for (g = 0; g < NCORE; g++) begin : g_core
            assign ev_all[g] = core_ev[g*EV_W +: EV_W];
        end
    endgenerate
    assign ev_all[NCORE]   = gfx_ev;
    assign ev_all[NCORE+1] = io_ev;

    generate
        for (g = 0; g < ND; g++) begin : g_cnt
            pe_evt_counter #(.EV_W(EV_W), .CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .ev    (ev_all[g]),
                .clr   (boundary),
                .total (cnt_tot[g])
            );
        end
    endgenerate

    pe_leak_scale #(.BASE_W(BASE_W), .LUT_W(LUT_W), .FRAC(FRAC), .PWR_W(PWR_W)) u_leak (
        .base (s_q.base),
        .vmul (s_q.vtab[vcode]),
        .tmul (s_q.ttab[tcode]),
        .leak (leak_nx)
    );

    always_comb begin
        acc  = WS'(leak_nx);
        prod = '0;
        for (int d = 0; d < ND; d++) begin
            prod = WM'(cnt_tot[d]) * WM'(s_q.wgt[d]);
            dom_nx[d] = (prod > WM'({PWR_W{1'b1}})) ? {PWR_W{1'b1}} : prod[PWR_W-1:0];
            acc = acc + WS'(dom_nx[d]);
        end
        pkg_nx = (acc > WS'({PWR_W{1'b1}})) ? {PWR_W{1'b1}} : acc[PWR_W-1:0];
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.tick  = boundary ? '0 : s_q.tick + 1'b1;
        if (boundary) begin
            s_d.dom   = dom_nx;
            s_d.leak  = leak_nx;
            s_d.pkg   = pkg_nx;
            s_d.valid = 1'b1;
        end
        if (wr_en) begin
            if (wr_addr < 6'(ND))
                s_d.wgt[wr_addr[$clog2(ND)-1:0]] = wr_data[WGT_W-1:0];
            else if (wr_addr == A_BASE)
                s_d.base = wr_data;
            else if (wr_addr[5:4] == PG_VTAB && wr_addr[3:0] < 4'(VN))
                s_d.vtab[wr_addr[VC_W-1:0]] = wr_data[LUT_W-1:0];
            else if (wr_addr[5:4] == PG_TTAB && wr_addr[3:0] < 4'(TN))
                s_d.ttab[wr_addr[TC_W-1:0]] = wr_data[LUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr < 6'(ND))           rd_data = s_q.dom[rd_addr[$clog2(ND)-1:0]];
        else if (rd_addr == 6'(ND))     rd_data = s_q.leak;
        else if (rd_addr == 6'(ND + 1)) rd_data = s_q.pkg;
    end

    assign est_valid = s_q.valid;

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |=> !est_valid);
    a_r6_phase: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> s_q.tick == '0);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s_d.valid |=> $stable(s_q.pkg) && $stable(s_q.leak) && $stable(s_q.dom));
    a_r5_pkg_ge_leak: assert property (@(posedge clk) disable iff (!rst_n)
        est_valid |-> s_q.pkg >= s_q.leak);
    generate
        for (g = 0; g < ND; g++) begin : g_chk
            a_r5_pkg_ge_dom: assert property (@(posedge clk) disable iff (!rst_n)
                est_valid |-> s_q.pkg >= s_q.dom[g]);
        end
    endgenerate
endmodule

// File: tb/sim_pwr_est_top.sv
module sim_pwr_est_top;
    localparam int ND = 4;
    localparam longint PMAX = 65535;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  core_ev = '0;
    logic [4:0]  gfx_ev = '0, io_ev = '0;
    logic [1:0]  vcode = '0, tcode = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        est_valid;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int last_v = 0;

    pwr_est_top u0 (
        .clk(clk), .rst_n(rst_n), .core_ev(core_ev), .gfx_ev(gfx_ev), .io_ev(io_ev),
        .vcode(vcode), .tcode(tcode), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .est_valid(est_valid)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d exp<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output longint v);
        rd_addr = 6'(a);
        #1;
        v = longint'(rd_data);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = 12'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic longint vt(input int v); return 40 + 24*v; endfunction
    function automatic longint tt(input int t); return 56 + 16*t; endfunction
    function automatic longint mn(input longint a, input longint b); return (a < b) ? a : b; endfunction

    task automatic wait_valid();
        int n = 0;
        do begin @(negedge clk); n++; end while (!est_valid && n < 200);
    endtask

    initial begin
        longint v, cnt, dp, sum, lk;
        int ev[ND], w[ND];
        int base, vc, tc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        chk("R7 valid", est_valid, 0);
        for (int a = 0; a < ND + 2; a++) begin rd(a, v); chk("R7 est", v, 0); end
        for (int i = 0; i < 4; i++) begin wr(8'h20 + i, int'(vt(i))); wr(8'h30 + i, int'(tt(i))); end
        wait_valid();
        last_v = cyc;
        for (int r = 0; r < 22; r++) begin
            vc = r % 4; tc = (r / 4) % 4;
            base = (r * 211 + 100) % 4096;
            for (int d = 0; d < ND; d++) begin
                ev[d] = (r * 3 + d * 5) % 32;
                w[d]  = (r * 37 + d * 11 + 1) % 256;
            end
            if (r == 20) begin base = 4095; for (int d = 0; d < ND; d++) begin ev[d] = 31; w[d] = 255; end end
            if (r == 21) for (int d = 0; d < ND; d++) ev[d] = 0;
            core_ev = {5'(ev[1]), 5'(ev[0])}; gfx_ev = 5'(ev[2]); io_ev = 5'(ev[3]);
            vcode = 2'(vc + 1); tcode = 2'(tc + 3);   // decoys, replaced before interval end
            for (int d = 0; d < ND; d++) begin
                wr(d, w[d]);
                if (d == 0) chk("R6 single-cycle strobe", est_valid, 0);
            end
            wr(8'h10, base);
            vcode = 2'(vc); tcode = 2'(tc);            // R9: final-cycle codes count
            wait_valid();
            chk("R6 period", cyc - last_v, 16);
            last_v = cyc;
            sum = 0;
            for (int d = 0; d < ND; d++) begin
                cnt = mn(longint'(ev[d]) * 16, 255);   // R1, R2
                dp  = mn(cnt * w[d], PMAX);            // R3
                sum += dp;
                rd(d, v); chk("R3 domain (R1/R2 count)", v, dp);
            end
            lk = mn((longint'(base) * vt(vc) * tt(tc)) >> 12, PMAX);
            rd(ND, v); chk("R4/R9 leakage", v, lk);
            rd(ND + 1, v); chk("R5 package", v, mn(sum + lk, PMAX));
            rd(ND + 2, v); chk("R8 unmapped read", v, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule